// File: doc/BRIEF.md
# Time-of-day and calendar update engine

This block holds a seven-byte time and calendar count (seconds, minutes, hours, day of week, date, month, year) and three alarm bytes (seconds, minutes, hours). Each pulse on `sec_tick` advances the count by one second. The seconds carry into minutes, the minutes into hours, the hours into the day of week and the date, the date into the month and the month into the year. Month lengths follow the calendar, and February has 29 days in every year that divides by four. All bytes are held either in binary or in packed BCD, chosen by `bin_mode`. The hours byte runs in 24-hour form or in 12-hour form with a PM flag, chosen by `h24_mode`.

Software sees a separate user copy through a byte-wide write port and a combinational read port. While `set_mode` is low, the user copy follows the count. While `set_mode` is high, the user copy is frozen and only software writes change it, but the count keeps advancing. When `set_mode` falls, only the bytes written during the frozen period replace the matching bytes of the count, and the user copy takes the merged result in the same cycle.

Each update also compares the new hours, minutes and seconds with the alarm bytes. An alarm byte whose two top bits are both set matches any value. The block gives one-cycle `update_done` and `alarm_hit` pulses. It also keeps an update-pending status that a warning input sets ahead of the update.

Top module: `rtc_cal_engine`

## Requirements
- R1: After reset, every address reads 00, and `update_done`, `alarm_hit` and `uip` are low.
- R2: With `bin_mode`=1 every byte holds a plain binary value. With `bin_mode`=0 every byte holds packed BCD, tens digit in bits 7:4 and units digit in bits 3:0. Every update writes its results in the selected encoding.
- R3: In 24-hour mode (`h24_mode`=1) the seconds and minutes wrap from 59 to 0 and carry into the next field. The hours wrap from 23 to 0 and carry into the day.
- R4: In 12-hour mode (`h24_mode`=0) the hours byte holds 1-12 in bits 6:0, and bit 7 is 1 for PM. The change from 11 to 12 toggles bit 7. The change from 11 PM to 12 AM carries into the day. The change from 12 to 1 leaves bit 7 unchanged.
- R5: The day of week advances on every day carry and wraps from 7 to 1.
- R6: On a day carry the date returns to 1 and the month advances after the last day of the month. Months 4, 6, 9 and 11 have 30 days, months 1, 3, 5, 7, 8, 10 and 12 have 31 days, and month 2 has 29 days when the year value divides by 4 (00 included) and 28 days otherwise.
- R7: The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 00.
- R8: While `set_mode`=1, the user copy changes only through writes, and ticks still advance the internal count. In the cycle after `set_mode` falls, the user copy shows the advanced count, with the bytes written during the frozen period taking the written values.
- R9: `alarm_hit` pulses in the same cycle as `update_done` when each of the updated seconds, minutes and hours bytes equals its alarm byte, or when that alarm byte has bits 7:6 = 11. The whole hours byte is compared, PM bit included.
- R10: `update_done` is high for exactly the one cycle after each `sec_tick`, whatever the value of `set_mode`.
- R11: `uip` rises in the cycle after a `uip_warn` pulse while `set_mode`=0. It is low in the cycle after a tick, and low in every cycle after one with `set_mode`=1.
- R12: The address map is: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 8 seconds alarm, 9 minutes alarm, 10 hours alarm. A write to address 7 or to 11-15 is ignored, and those addresses read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse that advances the count by one second |
| uip_warn | input | 1 | One-cycle pulse that signals an update is coming |
| set_mode | input | 1 | Freezes the user copy and stages writes while high |
| bin_mode | input | 1 | 1 for binary bytes, 0 for packed BCD |
| h24_mode | input | 1 | 1 for 24-hour hours, 0 for 12-hour hours with PM in bit 7 |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | User copy byte at `rd_addr` (combinational) |
| update_done | output | 1 | One-cycle pulse after each update |
| alarm_hit | output | 1 | One-cycle pulse when the updated time matches the alarm |
| uip | output | 1 | Update-pending status |

## Verification
The range assertions assume that every loaded byte is valid in the current encoding and hour form. They also assume that `bin_mode` and `h24_mode` change only before a full reload of the seven time bytes. The pulse and carry assertions assume that `sec_tick` is a single-cycle pulse with idle cycles between pulses, and that no write lands in the same cycle as a tick. The stimulus keeps to these limits: it changes modes only before a reload, it loads every time value through a frozen `set_mode` window, it drives each tick as one isolated cycle, and it takes every expected byte from its own hour-of-day and day-count arithmetic.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned BW     = 8;
  localparam int unsigned AW     = 4;
  localparam int unsigned VW     = 7;
  localparam int unsigned NTOD   = 7;
  localparam int unsigned NREG   = 11;
  localparam int unsigned A_SEC  = 0;
  localparam int unsigned A_MIN  = 1;
  localparam int unsigned A_HR   = 2;
  localparam int unsigned A_DOW  = 3;
  localparam int unsigned A_DATE = 4;
  localparam int unsigned A_MON  = 5;
  localparam int unsigned A_YR   = 6;
  localparam int unsigned A_GAP  = 7;
  localparam int unsigned A_SAL  = 8;
  localparam int unsigned A_MAL  = 9;
  localparam int unsigned A_HAL  = 10;

  typedef logic [BW-1:0] byte_t;
  typedef logic [VW-1:0] val_t;

  typedef struct packed {
    byte_t yr;
    byte_t mon;
    byte_t date;
    byte_t dow;
    byte_t hr;
    byte_t mn;
    byte_t sec;
  } tod_t;

  // stored byte -> plain value
  function automatic val_t dec(input byte_t b, input logic bin);
    val_t hi;
    val_t lo;
    hi = {3'b000, b[7:4]};
    lo = {3'b000, b[3:0]};
    return bin ? b[VW-1:0] : val_t'(hi * val_t'(10) + lo);
  endfunction

  // plain value -> stored byte
  function automatic byte_t enc(input val_t v, input logic bin);
    val_t tens;
    val_t ones;
    tens = v / val_t'(10);
    ones = v % val_t'(10);
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  function automatic val_t month_days(input val_t mon, input val_t yr);
    case (mon)
      val_t'(2):                                  return (yr[1:0] == 2'b00) ? val_t'(29) : val_t'(28);
      val_t'(4), val_t'(6), val_t'(9), val_t'(11): return val_t'(30);
      default:                                    return val_t'(31);
    endcase
  endfunction

  function automatic logic is_wild(input byte_t a);
    return a[7] & a[6];
  endfunction

  function automatic logic alarm_ok(input byte_t t, input byte_t a);
    return is_wild(a) || (t == a);
  endfunction

endpackage

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
  import rtc_cal_pkg::*;
(
  input  tod_t cur,
  input  logic bin,
  input  logic h24,
  output tod_t nxt,
  output logic day_roll
);

  val_t  s, m, h, dw, d, mo, y, dim;
  val_t  s_n, m_n, h_n, dw_n, d_n, mo_n, y_n;
  logic  pm, pm_n, c_min, c_hr, c_mon, c_yr;
  byte_t hr_e;

  always_comb begin
    s   = dec(cur.sec, bin);
    m   = dec(cur.mn, bin);
    h   = dec({1'b0, cur.hr[6:0]}, bin);
    pm  = ~h24 & cur.hr[7];
    dw  = dec(cur.dow, bin);
    d   = dec(cur.date, bin);
    mo  = dec(cur.mon, bin);
    y   = dec(cur.yr, bin);
    dim = month_days(mo, y);

    c_min = (s >= val_t'(59));
    s_n   = c_min ? '0 : s + val_t'(1);

    c_hr = c_min && (m >= val_t'(59));
    m_n  = c_min ? (c_hr ? '0 : m + val_t'(1)) : m;

    h_n      = h;
    pm_n     = pm;
    day_roll = 1'b0;
    if (c_hr) begin
      if (h24) begin
        if (h >= val_t'(23)) begin
          h_n      = '0;
          day_roll = 1'b1;
        end else begin
          h_n = h + val_t'(1);
        end
      end else if (h == val_t'(11)) begin
        h_n      = val_t'(12);
        pm_n     = ~pm;
        day_roll = pm;
      end else if (h >= val_t'(12)) begin
        h_n = val_t'(1);
      end else begin
        h_n = h + val_t'(1);
      end
    end

    dw_n  = day_roll ? ((dw >= val_t'(7)) ? val_t'(1) : dw + val_t'(1)) : dw;
    c_mon = day_roll && (d >= dim);
    d_n   = day_roll ? (c_mon ? val_t'(1) : d + val_t'(1)) : d;
    c_yr  = c_mon && (mo >= val_t'(12));
    mo_n  = c_mon ? (c_yr ? val_t'(1) : mo + val_t'(1)) : mo;
    y_n   = c_yr ? ((y >= val_t'(99)) ? '0 : y + val_t'(1)) : y;

    hr_e     = enc(h_n, bin);
    nxt.sec  = enc(s_n, bin);
    nxt.mn   = enc(m_n, bin);
    nxt.hr   = h24 ? hr_e : {pm_n, hr_e[6:0]};
    nxt.dow  = enc(dw_n, bin);
    nxt.date = enc(d_n, bin);
    nxt.mon  = enc(mo_n, bin);
    nxt.yr   = enc(y_n, bin);
  end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_cal_pkg::*;
(
  input  tod_t  now,
  input  byte_t al_sec,
  input  byte_t al_min,
  input  byte_t al_hr,
  output logic  match
);

  logic sec_ok, min_ok, hr_ok;

  assign sec_ok = alarm_ok(now.sec, al_sec);
  assign min_ok = alarm_ok(now.mn, al_min);
  assign hr_ok  = alarm_ok(now.hr, al_hr);
  assign match  = sec_ok & min_ok & hr_ok;

endmodule

// File: rtl/rtc_uip_track.sv
module rtc_uip_track (
  input  logic clk,
  input  logic rst_n,
  input  logic warn,
  input  logic tick,
  input  logic set_mode,
  output logic uip
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                uip <= 1'b0;
    else if (set_mode || tick) uip <= 1'b0;
    else if (warn)             uip <= 1'b1;
  end

  // R11: a set_mode cycle leaves the status low
  a_r11_clear_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode |=> !uip);

  // R11: the update itself ends the pending status
  a_r11_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !uip);

endmodule

// File: rtl/rtc_cal_engine.sv
module rtc_cal_engine
  import rtc_cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic          uip_warn,
  input  logic          set_mode,
  input  logic          bin_mode,
  input  logic          h24_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [BW-1:0] rd_data,
  output logic          update_done,
  output logic          alarm_hit,
  output logic          uip
);

  byte_t cnt_q [NREG];
  byte_t usr_q [NREG];
  byte_t base  [NREG];
  byte_t nxt_b [NREG];
  byte_t cnt_d [NREG];
  byte_t usr_d [NREG];
  logic  dirty_q [NREG];
  logic  wr_hit  [NREG];

  logic              set_q;
  logic              release_evt;
  logic              day_roll;
  logic              match;
  tod_t              base_tod;
  tod_t              nxt_tod;
  logic [NREG*BW-1:0] usr_flat;

  assign release_evt = set_q & ~set_mode;

  for (genvar i = 0; i < NREG; i++) begin : g_byte
    assign wr_hit[i] = wr_en && (wr_addr == AW'(i)) && (i != A_GAP);
    assign base[i]   = (release_evt && dirty_q[i]) ? usr_q[i] : cnt_q[i];
    if (i < NTOD) begin : g_tod
      assign nxt_b[i] = nxt_tod[i*BW +: BW];
    end else begin : g_keep
      assign nxt_b[i] = base[i];
    end
    assign cnt_d[i] = (wr_hit[i] && !set_mode) ? wr_data
                    : (sec_tick ? nxt_b[i] : base[i]);
    assign usr_d[i] = wr_hit[i] ? wr_data : (set_mode ? usr_q[i] : cnt_d[i]);
    assign usr_flat[i*BW +: BW] = usr_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[i]   <= '0;
        usr_q[i]   <= '0;
        dirty_q[i] <= 1'b0;
      end else begin
        cnt_q[i]   <= cnt_d[i];
        usr_q[i]   <= usr_d[i];
        dirty_q[i] <= set_mode & (dirty_q[i] | wr_hit[i]);
      end
    end
  end

  assign base_tod = {base[A_YR], base[A_MON], base[A_DATE], base[A_DOW],
                     base[A_HR], base[A_MIN], base[A_SEC]};

  rtc_cal_advance adv_i (
    .cur      (base_tod),
    .bin      (bin_mode),
    .h24      (h24_mode),
    .nxt      (nxt_tod),
    .day_roll (day_roll)
  );

  rtc_alarm_cmp alm_i (
    .now    (nxt_tod),
    .al_sec (base[A_SAL]),
    .al_min (base[A_MAL]),
    .al_hr  (base[A_HAL]),
    .match  (match)
  );

  rtc_uip_track uip_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .warn     (uip_warn),
    .tick     (sec_tick),
    .set_mode (set_mode),
    .uip      (uip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q       <= 1'b0;
      update_done <= 1'b0;
      alarm_hit   <= 1'b0;
    end else begin
      set_q       <= set_mode;
      update_done <= sec_tick;
      alarm_hit   <= sec_tick & match;
    end
  end

  assign rd_data = (int'(rd_addr) < NREG) ? usr_q[rd_addr] : '0;

  // R10: isolated ticks give isolated completion pulses
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |=> !update_done);

  // R9: an alarm pulse only ever comes with an update
  a_r9_alarm_with_update: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> update_done);

  // R8: frozen user copy moves only through writes
  a_r8_user_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !wr_en) |=> $stable(usr_flat));

  // R3: seconds stay in range after an update
  a_r3_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |-> (dec(cnt_q[A_SEC], bin_mode) <= val_t'(59)));

  // R5: a day carry lands on a valid weekday
  a_r5_dow_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && day_roll) |=> ((cnt_q[A_DOW] >= 8'd1) && (cnt_q[A_DOW] <= 8'd7)));

  // R6: the date never passes the length of its month
  a_r6_date_in_month: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |-> (dec(cnt_q[A_DATE], bin_mode) <=
                     month_days(dec(cnt_q[A_MON], bin_mode), dec(cnt_q[A_YR], bin_mode))));

endmodule

// File: tb/rtc_cal_engine_tb.sv
module rtc_cal_engine_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       uip_warn = 1'b0;
  logic       set_mode = 1'b0;
  logic       bin_mode = 1'b1;
  logic       h24_mode = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       update_done;
  logic       alarm_hit;
  logic       uip;

  int n_chk = 0;
  int n_err = 0;
  int ms, mm, mh, mdow, md, mmo, my;
  logic [7:0] rv;

  always #5 clk = ~clk;

  rtc_cal_engine dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .uip_warn(uip_warn),
    .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .update_done(update_done), .alarm_hit(alarm_hit), .uip(uip)
  );

  function automatic logic [7:0] benc(input int v);
    if (bin_mode) return 8'(v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic logic [7:0] hour_byte(input int hh);
    int h12;
    if (h24_mode) return benc(hh);
    h12 = (hh % 12 == 0) ? 12 : hh % 12;
    return benc(h12) | ((hh >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo < 8) return 30 + (mo % 2);
    return 31 - (mo % 2);
  endfunction

  function automatic logic [7:0] model_byte(input int a);
    case (a)
      0: return benc(ms);
      1: return benc(mm);
      2: return hour_byte(mh);
      3: return benc(mdow);
      4: return benc(md);
      5: return benc(mmo);
      default: return benc(my);
    endcase
  endfunction

  task automatic model_step();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mdow = (mdow % 7) + 1;
          md++;
          if (md > mdays(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin
              mmo = 1;
              my = (my + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    rd_addr = 4'(a);
    #1;
    d = rd_data;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_clock(input int s, input int m, input int h, input int dw,
                           input int d, input int mo, input int y);
    ms = s; mm = m; mh = h; mdow = dw; md = d; mmo = mo; my = y;
    @(negedge clk); set_mode = 1'b1;
    for (int a = 0; a < 7; a++) wr(a, model_byte(a));
    @(negedge clk); set_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_alarm(input logic [7:0] sa, input logic [7:0] ma, input logic [7:0] ha);
    @(negedge clk); set_mode = 1'b1;
    wr(8, sa); wr(9, ma); wr(10, ha);
    @(negedge clk); set_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick_chk(input bit chk_hit, input bit exp_hit);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    check(update_done == 1'b1, "R10 done pulse", int'(update_done), 1);
    if (chk_hit) check(alarm_hit == exp_hit, "R9 alarm hit", int'(alarm_hit), int'(exp_hit));
    @(negedge clk);
    check(update_done == 1'b0 && alarm_hit == 1'b0, "R10 pulse width",
          int'({update_done, alarm_hit}), 0);
    model_step();
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 7; a++) begin
      rd(a, rv);
      check(rv == model_byte(a), req, int'(rv), int'(model_byte(a)));
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, rv);
      check(rv == 8'h00, "R1 reset byte", int'(rv), 0);
    end
    check(!uip && !update_done && !alarm_hit, "R1 reset outputs",
          int'({uip, update_done, alarm_hit}), 0);

    // R12 gaps ignored, alarm bytes at 8..10
    wr(7, 8'h55); wr(12, 8'hAA);
    rd(7, rv);  check(rv == 8'h00, "R12 addr 7", int'(rv), 0);
    rd(12, rv); check(rv == 8'h00, "R12 addr 12", int'(rv), 0);
    rd(0, rv);  check(rv == 8'h00, "R12 sec untouched", int'(rv), 0);
    set_alarm(8'h11, 8'h22, 8'h33);
    rd(8, rv);  check(rv == 8'h11, "R12 sec alarm", int'(rv), 'h11);
    rd(9, rv);  check(rv == 8'h22, "R12 min alarm", int'(rv), 'h22);
    rd(10, rv); check(rv == 8'h33, "R12 hr alarm", int'(rv), 'h33);

    // R3 seconds/minutes sweep binary, R2 in BCD
    bin_mode = 1'b1; h24_mode = 1'b1;
    set_clock(0, 0, 0, 1, 1, 1, 0);
    for (int k = 0; k < 125; k++) begin tick_chk(0, 0); check_all("R3 sweep binary"); end
    bin_mode = 1'b0;
    set_clock(50, 58, 9, 2, 3, 4, 5);
    for (int k = 0; k < 80; k++) begin tick_chk(0, 0); check_all("R2 sweep bcd"); end

    // R3 / R4 hour sweep in both encodings and both hour forms
    for (int e = 0; e < 2; e++) begin
      for (int hm = 0; hm < 2; hm++) begin
        for (int h = 0; h < 24; h++) begin
          bin_mode = e[0]; h24_mode = hm[0];
          set_clock(59, 59, h, (h % 7) + 1, 15, 6, 10);
          tick_chk(0, 0);
          check_all(hm ? "R3 hour roll" : "R4 12h roll");
        end
      end
    end

    // R5 weekday wrap
    bin_mode = 1'b0; h24_mode = 1'b1;
    for (int dw = 1; dw <= 7; dw++) begin
      set_clock(59, 59, 23, dw, 10, 3, 21);
      tick_chk(0, 0);
      check_all("R5 weekday");
    end

    // R6 month ends, R7 year end
    for (int e = 0; e < 2; e++) begin
      bin_mode = e[0];
      for (int mo = 1; mo <= 12; mo++) begin
        set_clock(59, 59, 23, 2, mdays(mo, 98), mo, 98);
        tick_chk(0, 0);
        check_all(mo == 12 ? "R7 month wrap" : "R6 month end");
      end
      set_clock(59, 59, 23, 4, 31, 12, 99);
      tick_chk(0, 0);
      check_all("R7 year wrap");
    end

    // R6 leap years over the whole century
    for (int y = 0; y < 100; y++) begin
      bin_mode = y[0];
      set_clock(59, 59, 23, 1, 28, 2, y);
      tick_chk(0, 0);
      check_all("R6 feb 28");
      if (y % 4 == 0) begin
        set_clock(59, 59, 23, 1, 29, 2, y);
        tick_chk(0, 0);
        check_all("R6 feb 29");
      end
    end

    // R9 alarms
    bin_mode = 1'b0; h24_mode = 1'b1;
    set_alarm(8'h15, 8'h30, 8'h06);
    set_clock(14, 30, 6, 1, 1, 1, 1); tick_chk(1, 1);
    set_clock(15, 30, 6, 1, 1, 1, 1); tick_chk(1, 0);
    set_alarm(8'h00, 8'h00, 8'hC0);
    set_clock(59, 59, 7, 1, 1, 1, 1); tick_chk(1, 1);
    tick_chk(1, 0);
    set_alarm(8'h00, 8'hC5, 8'hFF);
    set_clock(59, 27, 13, 1, 1, 1, 1); tick_chk(1, 1);
    tick_chk(1, 0);
    set_alarm(8'hFF, 8'hFF, 8'hFF);
    for (int k = 0; k < 3; k++) tick_chk(1, 1);
    h24_mode = 1'b0;
    set_alarm(8'h00, 8'h00, 8'h81);
    set_clock(59, 59, 0, 1, 1, 1, 1);  tick_chk(1, 0);
    set_clock(59, 59, 12, 1, 1, 1, 1); tick_chk(1, 1);
    check_all("R9 12h pm time");

    // R8 frozen copy with staged write
    h24_mode = 1'b1;
    set_alarm(8'h00, 8'h00, 8'h00);
    set_clock(30, 20, 10, 3, 5, 5, 5);
    @(negedge clk); set_mode = 1'b1;
    for (int k = 0; k < 3; k++) tick_chk(0, 0);
    rd(0, rv); check(rv == 8'h30, "R8 frozen sec", int'(rv), 'h30);
    rd(2, rv); check(rv == 8'h10, "R8 frozen hr", int'(rv), 'h10);
    wr(1, 8'h45);
    rd(1, rv); check(rv == 8'h45, "R8 staged write", int'(rv), 'h45);
    @(negedge clk); set_mode = 1'b0;
    @(negedge clk);
    mm = 45;
    check_all("R8 release merge");

    // R11 update pending status
    @(negedge clk); uip_warn = 1'b1;
    @(negedge clk); uip_warn = 1'b0;
    check(uip == 1'b1, "R11 warn sets", int'(uip), 1);
    tick_chk(0, 0);
    check(uip == 1'b0, "R11 tick clears", int'(uip), 0);
    @(negedge clk); uip_warn = 1'b1;
    @(negedge clk); uip_warn = 1'b0;
    check(uip == 1'b1, "R11 warn sets again", int'(uip), 1);
    set_mode = 1'b1;
    @(negedge clk);
    check(uip == 1'b0, "R11 set clears", int'(uip), 0);
    uip_warn = 1'b1;
    @(negedge clk); uip_warn = 1'b0;
    check(uip == 1'b0, "R11 warn blocked by set", int'(uip), 0);
    set_mode = 1'b0;
    @(negedge clk);
    check_all("R8 release without writes");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule